// File: doc/BRIEF.md
# Flash Multi-Sector Erase Command Sequencer

This block is the command front end of a NOR-style flash device for multi-sector erase. It watches single-cycle bus writes (address, data, strobe). It recognises the six-write erase pattern and collects the addressed sectors into a bitmap. An extendable acceptance window, measured in clock cycles, decides when collection stops. When that window runs out, the block hands the bitmap to an erase engine. The engine is modelled by a stub that finishes after a fixed number of cycles.

While the window is open, software may add sectors in any order. Each added sector restarts the window. A foreign command in the window cancels the whole request. Once erasing has begun, the only write that has any effect is a suspend. A suspended erase resumes on a sector-erase code. A synchronous reset aborts everything.

Top module: `flash_erase_seq`

## Requirements
- R1: The write sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at any address opens the acceptance window. Unlock addresses are compared on wr_addr[10:0] only. Opening the window sets erase_map bit wr_addr[15:12] of the final write and drives busy_n low.
- R2: A write that does not match the next expected step of the six-write sequence returns the block to idle. A 30 that follows it does not open a window.
- R3: In the window, each write of data 30 sets the bit of its sector in erase_map and restarts the window. A 30 written at most WIN_CYC cycles after the previous accepted sector write is accepted.
- R4: After WIN_CYC write-free cycles following the last accepted sector, the window closes and erasing begins, marked by a one-cycle erase_start pulse. A later 30 leaves erase_map unchanged.
- R5: In the window, a write whose data is neither 30 nor B0 clears erase_map, sets busy_n high and returns to idle.
- R6: win_closed is 0 in idle and in the window, and 1 while erasing.
- R7: While erasing, every write other than data B0 is ignored.
- R8: Data B0 written in the window or while erasing sets erase_suspended and busy_n high. In that state, a 30 resumes the erase and the erase cycle count continues where it stopped.
- R9: After ERASE_CYC unsuspended erase cycles, erase_done pulses for one cycle, erase_map clears, and busy_n returns high.
- R10: rst high at a clock edge returns all outputs to idle values (busy_n 1, everything else 0), including in the middle of an erase.
- R11: id_lock is 1 while the window is open, while erasing, and while suspended; it is 0 otherwise.
- R12: busy_n is low exactly while the window is open or erasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write word address; upper bits select the sector |
| wr_data | input | 8 | Write command data |
| busy_n | output | 1 | Low while the window is open or erasing |
| win_closed | output | 1 | Acceptance window has expired and erase runs |
| erase_suspended | output | 1 | Erase is suspended |
| id_lock | output | 1 | Identification and query reads refused |
| erase_start | output | 1 | One-cycle pulse handing erase_map to the engine |
| erase_done | output | 1 | One-cycle pulse when the erase finishes |
| erase_map | output | NUM_SECT | Sectors selected for erase |

## Verification
The hardest case to reach is the window boundary. A sector write that comes exactly WIN_CYC cycles after the previous one must still be accepted, and one that comes a cycle later must be ignored because erasing has begun. Directed stimulus sets up both gaps after an open window. Random episodes then draw gaps from a range that straddles the limit. They also draw suspends that land in the window and mid-erase, and resets that land during erasing. A cycle-level model in the bench predicts every output.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_U1, ST_U2, ST_SET, ST_U3, ST_U4, ST_WIN, ST_ERASE, ST_SUSP
    } fes_state_t;

    typedef enum logic [2:0] {
        CMD_UNLK_A, CMD_UNLK_B, CMD_SETUP, CMD_SECT, CMD_SUSP, CMD_OTHER
    } fes_cmd_t;

    localparam logic [10:0] ADDR_KEY_A = 11'h555;
    localparam logic [10:0] ADDR_KEY_B = 11'h2AA;
    localparam logic [7:0]  DAT_KEY_A  = 8'hAA;
    localparam logic [7:0]  DAT_KEY_B  = 8'h55;
    localparam logic [7:0]  DAT_SETUP  = 8'h80;
    localparam logic [7:0]  DAT_SECT   = 8'h30;
    localparam logic [7:0]  DAT_SUSP   = 8'hB0;

    function automatic fes_cmd_t classify(input logic [10:0] a, input logic [7:0] d);
        if (d == DAT_SECT)                      return CMD_SECT;
        if (d == DAT_SUSP)                      return CMD_SUSP;
        if (a == ADDR_KEY_A && d == DAT_KEY_A)  return CMD_UNLK_A;
        if (a == ADDR_KEY_B && d == DAT_KEY_B)  return CMD_UNLK_B;
        if (a == ADDR_KEY_A && d == DAT_SETUP)  return CMD_SETUP;
        return CMD_OTHER;
    endfunction

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 4
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output fes_cmd_t          cmd,
    output logic [SECT_W-1:0] sect
);
    assign cmd  = classify(wr_addr[10:0], wr_data);
    assign sect = wr_addr[ADDR_W-1 -: SECT_W];
endmodule

// File: rtl/fes_cycle_timer.sv
module fes_cycle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_SECT  = 16,
    parameter int WIN_CYC   = 64,
    parameter int ERASE_CYC = 200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    output logic                busy_n,
    output logic                win_closed,
    output logic                erase_suspended,
    output logic                id_lock,
    output logic                erase_start,
    output logic                erase_done,
    output logic [NUM_SECT-1:0] erase_map
);
    localparam int SECT_W = $clog2(NUM_SECT);

    fes_state_t          state_q, state_d;
    fes_cmd_t            cmd;
    logic [SECT_W-1:0]   sect;
    logic [NUM_SECT-1:0] map_q, map_d, sect_bit;
    logic                start_d, done_d;
    logic                accept_sect, win_exp, erase_fin, erase_run;
    logic                is_susp;

    fes_cmd_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd),
        .sect    (sect)
    );

    assign sect_bit = NUM_SECT'(1) << sect;
    assign is_susp  = wr_en && (cmd == CMD_SUSP);

    fes_cycle_timer #(.LIMIT(WIN_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept_sect),
        .run      ((state_q == ST_WIN) && !wr_en),
        .at_limit (win_exp)
    );

    assign erase_run = (state_q == ST_ERASE) && !is_susp;

    fes_cycle_timer #(.LIMIT(ERASE_CYC)) u_stub (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_q == ST_WIN),
        .run      (erase_run),
        .at_limit (erase_fin)
    );

    always_comb begin
        state_d     = state_q;
        map_d       = map_q;
        start_d     = 1'b0;
        done_d      = 1'b0;
        accept_sect = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (wr_en && cmd == CMD_UNLK_A) state_d = ST_U1;
            ST_U1:    if (wr_en) state_d = (cmd == CMD_UNLK_B) ? ST_U2  : ST_IDLE;
            ST_U2:    if (wr_en) state_d = (cmd == CMD_SETUP)  ? ST_SET : ST_IDLE;
            ST_SET:   if (wr_en) state_d = (cmd == CMD_UNLK_A) ? ST_U3  : ST_IDLE;
            ST_U3:    if (wr_en) state_d = (cmd == CMD_UNLK_B) ? ST_U4  : ST_IDLE;
            ST_U4: begin
                if (wr_en) begin
                    if (cmd == CMD_SECT) begin
                        state_d     = ST_WIN;
                        map_d       = sect_bit;
                        accept_sect = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WIN: begin
                if (wr_en) begin
                    if (cmd == CMD_SECT) begin
                        map_d       = map_q | sect_bit;
                        accept_sect = 1'b1;
                    end else if (cmd == CMD_SUSP) begin
                        state_d = ST_SUSP;
                    end else begin
                        state_d = ST_IDLE;
                        map_d   = '0;
                    end
                end else if (win_exp) begin
                    state_d = ST_ERASE;
                    start_d = 1'b1;
                end
            end
            ST_ERASE: begin
                if (is_susp) begin
                    state_d = ST_SUSP;
                end else if (erase_fin) begin
                    state_d = ST_IDLE;
                    map_d   = '0;
                    done_d  = 1'b1;
                end
            end
            ST_SUSP:  if (wr_en && cmd == CMD_SECT) state_d = ST_ERASE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            map_q       <= '0;
            erase_start <= 1'b0;
            erase_done  <= 1'b0;
        end else begin
            state_q     <= state_d;
            map_q       <= map_d;
            erase_start <= start_d;
            erase_done  <= done_d;
        end
    end

    assign erase_map       = map_q;
    assign busy_n          = !((state_q == ST_WIN) || (state_q == ST_ERASE));
    assign win_closed      = (state_q == ST_ERASE);
    assign erase_suspended = (state_q == ST_SUSP);
    assign id_lock         = (state_q == ST_WIN) || (state_q == ST_ERASE)
                          || (state_q == ST_SUSP);
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
    parameter int NUM_SECT = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [7:0]          wr_data,
    input logic                busy_n,
    input logic                win_closed,
    input logic                erase_suspended,
    input logic                id_lock,
    input logic                erase_start,
    input logic                erase_done,
    input logic [NUM_SECT-1:0] erase_map
);
    logic in_win;
    assign in_win = !busy_n && !win_closed;

    // R6
    erase_busy_chk: assert property (@(posedge clk) disable iff (rst)
        win_closed |-> !busy_n);

    // R4
    start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (win_closed && $past(in_win)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        erase_done |-> (busy_n && erase_map == '0 && !erase_suspended));

    // R5
    foreign_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (in_win && wr_en && wr_data != 8'h30 && wr_data != 8'hB0)
            |=> (busy_n && erase_map == '0));

    // R3
    map_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_win && $past(in_win)) |-> ((erase_map & $past(erase_map)) == $past(erase_map)));

    // R8
    susp_ready_chk: assert property (@(posedge clk) disable iff (rst)
        erase_suspended |-> busy_n);

    // R11
    lock_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_n |-> id_lock);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (busy_n && erase_map == '0 && !erase_suspended && !id_lock));
endmodule

bind flash_erase_seq fes_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .busy_n          (busy_n),
    .win_closed      (win_closed),
    .erase_suspended (erase_suspended),
    .id_lock         (id_lock),
    .erase_start     (erase_start),
    .erase_done      (erase_done),
    .erase_map       (erase_map)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
    localparam int AW = 16, NS = 16, W = 16, EC = 40;

    logic clk = 0, rst = 1, wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic busy_n, win_closed, erase_suspended, id_lock, erase_start, erase_done;
    logic [NS-1:0] erase_map;

    int errors = 0, checks = 0, cycles = 0;

    flash_erase_seq #(.ADDR_W(AW), .NUM_SECT(NS), .WIN_CYC(W), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy_n(busy_n), .win_closed(win_closed), .erase_suspended(erase_suspended),
        .id_lock(id_lock), .erase_start(erase_start), .erase_done(erase_done),
        .erase_map(erase_map));

    always #4 clk = ~clk;

    // reference model: 0..5 unlock progress, 6 window, 7 erasing, 8 suspended
    int m_st = 0, m_tmr = 0, m_ecnt = 0;
    logic [NS-1:0] m_map = '0;
    logic m_start = 0, m_done = 0;

    function automatic int kind(input logic [AW-1:0] a, input logic [7:0] d);
        // 1 key A, 2 key B, 3 setup, 4 sector, 5 suspend, 0 other
        if (d == 8'h30) return 4;
        if (d == 8'hB0) return 5;
        if (a[10:0] == 11'h555 && d == 8'hAA) return 1;
        if (a[10:0] == 11'h2AA && d == 8'h55) return 2;
        if (a[10:0] == 11'h555 && d == 8'h80) return 3;
        return 0;
    endfunction

    function automatic int want(input int step);
        case (step)
            0, 3: return 1;
            1, 4: return 2;
            2:    return 3;
            default: return 4;
        endcase
    endfunction

    always @(posedge clk) begin
        int k;
        k = kind(wr_addr, wr_data);
        m_start = 0; m_done = 0;
        if (rst) begin
            m_st = 0; m_map = '0; m_tmr = 0; m_ecnt = 0;
        end else if (m_st <= 5) begin
            if (wr_en) begin
                if (k == want(m_st)) begin
                    if (m_st == 5) begin
                        m_st = 6; m_map = '0; m_map[wr_addr[15:12]] = 1'b1; m_tmr = 0;
                    end else m_st++;
                end else m_st = 0;
            end
        end else if (m_st == 6) begin
            m_ecnt = 0;
            if (wr_en) begin
                if (k == 4) begin m_map[wr_addr[15:12]] = 1'b1; m_tmr = 0; end
                else if (k == 5) m_st = 8;
                else begin m_st = 0; m_map = '0; end
            end else if (m_tmr == W - 1) begin
                m_st = 7; m_start = 1;
            end else m_tmr++;
        end else if (m_st == 7) begin
            if (wr_en && k == 5) m_st = 8;
            else if (m_ecnt == EC - 1) begin m_st = 0; m_map = '0; m_done = 1; end
            else m_ecnt++;
        end else begin
            if (wr_en && k == 4) m_st = 7;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check("R12 busy_n", busy_n, !(m_st == 6 || m_st == 7));
        check("R6 win_closed", win_closed, m_st == 7);
        check("R8 erase_suspended", erase_suspended, m_st == 8);
        check("R11 id_lock", id_lock, m_st >= 6);
        check("R4 erase_start", erase_start, m_start);
        check("R9 erase_done", erase_done, m_done);
        check("R3 erase_map", erase_map, m_map);
    endtask

    task automatic tick(input logic we, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cycles++;
        compare_all();
        wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, '0, '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        tick(1, a, d);
    endtask

    task automatic open_seq(input logic [3:0] s);
        wr({5'h1F, 11'h555}, 8'hAA);
        wr({5'h03, 11'h2AA}, 8'h55);
        wr({5'h00, 11'h555}, 8'h80);
        wr({5'h0A, 11'h555}, 8'hAA);
        wr({5'h11, 11'h2AA}, 8'h55);
        wr({s, 12'h123}, 8'h30);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; wr_en = 0;
        @(negedge clk); rst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        check("R10 reset busy_n", busy_n, 1);
        check("R10 reset map", erase_map, 0);

        // R1 R6 R11: window opens on sector 5
        open_seq(4'd5);
        tick(0, '0, '0);
        check("R1 map", erase_map, 16'h0020);
        check("R1 busy_n", busy_n, 0);
        check("R6 dq3 open", win_closed, 0);
        check("R11 lock", id_lock, 1);
        // R3: gap of exactly W cycles accepted
        idle(W - 2);
        wr({4'd9, 12'h0}, 8'h30);
        tick(0, '0, '0);
        check("R3 edge accept", erase_map, 16'h0220);
        // R4 R7: gap of W+1 cycles rejected
        idle(W - 1);
        wr({4'd2, 12'h0}, 8'h30);
        tick(0, '0, '0);
        check("R4 late reject", erase_map, 16'h0220);
        check("R6 dq3 erase", win_closed, 1);
        wr({5'h00, 11'h555}, 8'hAA);
        tick(0, '0, '0);
        check("R7 ignore", win_closed, 1);
        // R8: suspend, then resume
        wr('0, 8'hB0);
        tick(0, '0, '0);
        check("R8 suspended", erase_suspended, 1);
        check("R8 busy_n", busy_n, 1);
        wr('0, 8'h30);
        idle(EC + 4);
        check("R9 finished", busy_n, 1);
        check("R9 map clear", erase_map, 0);

        // R2: broken unlock, then a bare 30
        wr({5'h0, 11'h555}, 8'hAA);
        wr({5'h0, 11'h2AA}, 8'h55);
        wr({5'h0, 11'h555}, 8'h90);
        wr({4'd3, 12'h0}, 8'h30);
        tick(0, '0, '0);
        check("R2 no window", busy_n, 1);

        // R5: foreign command cancels
        open_seq(4'd7);
        idle(3);
        wr({5'h0, 11'h555}, 8'hF0);
        tick(0, '0, '0);
        check("R5 cancel map", erase_map, 0);
        check("R5 cancel busy", busy_n, 1);

        // R10: reset mid-erase
        open_seq(4'd1);
        idle(W + 5);
        do_reset();
        check("R10 abort busy", busy_n, 1);
        check("R10 abort map", erase_map, 0);

        // constrained random episodes
        void'($urandom(32'h5EED_F1A5));
        for (int ep = 0; ep < 250; ep++) begin
            int bad;
            bad = $urandom_range(0, 9);
            if (bad < 6) begin
                for (int st = 0; st < 6; st++) begin
                    logic [AW-1:0] a;
                    logic [7:0] d;
                    a = {$urandom_range(0, 31), 11'h0};
                    case (want(st))
                        1: begin a[10:0] = 11'h555; d = 8'hAA; end
                        2: begin a[10:0] = 11'h2AA; d = 8'h55; end
                        3: begin a[10:0] = 11'h555; d = 8'h80; end
                        default: d = 8'h30;
                    endcase
                    if (bad == 0 && $urandom_range(0, 5) == st) d = 8'($urandom);
                    wr(a, d);
                    idle($urandom_range(0, 2));
                end
            end
            for (int x = 0; x < $urandom_range(0, 5); x++) begin
                int pick;
                pick = $urandom_range(0, 19);
                idle($urandom_range(W - 3, W + 2));
                if (pick < 14)      wr({4'($urandom), 12'($urandom)}, 8'h30);
                else if (pick < 17) wr('0, 8'hB0);
                else                wr(16'($urandom), 8'($urandom));
            end
            idle($urandom_range(0, EC));
            if ($urandom_range(0, 5) == 0) wr('0, 8'hB0);
            if ($urandom_range(0, 3) == 0) begin idle(3); wr('0, 8'h30); end
            if ($urandom_range(0, 12) == 0) do_reset();
            idle($urandom_range(W, W + EC + 4));
            if (m_st == 8) begin wr('0, 8'h30); idle(EC + 2); end
        end
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule